// File: doc/BRIEF.md
# Word-Coherent Read Prefetch

This block sits on the transmit side of a byte-serial slave and guarantees that a master reading a 16-bit word receives both halves as they stood at a single instant. A read command starts a burst that fetches two bytes from the buffer RAM in back-to-back single-cycle reads. The byte at the even address 2n, which holds the most significant half of the word, is loaded into the transmit shift register. The byte at 2n+1 is parked in an internal shadow register.

When the master asks for a second byte in the same message, the shadow byte is transmitted and the RAM is not read again. A CPU write to address 2n+1 after the fetch therefore cannot tear the word. A stop or repeated start invalidates the shadow. A third byte request in the same message starts a new two-byte fetch from the next even address. The RAM is reached through a request/grant handshake. A stall output tells the CPU when the block holds the RAM, and a clock-hold output keeps the serial clock stretched until the first byte of a fetch is ready.

Top module: `wcr_prefetch`

## Requirements
- R1: While reset is high, and in the cycle after it, `tx_load`, `ram_req`, `cpu_stall` and `scl_hold` are all low.
- R2: On a `rd_cmd` with address A, the block requests address A with bit 0 cleared (2n) and then 2n+1 on the next granted cycle. The byte read from 2n is the first byte presented on `tx_data` with a one-cycle `tx_load` pulse.
- R3: A `byte_req` in the same message after a fetch transmits the byte read from 2n+1 at fetch time, even if that RAM location was changed after the fetch.
- R4: A `byte_req` in the same message after the shadow byte was sent starts a new fetch at base+2, wrapping modulo 2^AW. Its even byte is transmitted and its odd byte is shadowed.
- R5: `msg_end` (stop or repeated start) invalidates the shadow and aborts any fetch in progress. Until the next `rd_cmd`, `byte_req` causes no `tx_load` and no `ram_req`. A fetch aborted before its data returns loads nothing.
- R6: A new `rd_cmd` overwrites an unused shadow byte, so the following `byte_req` transmits the odd byte of the new word.
- R7: `cpu_stall` is high only in cycles where the RAM grants a request, and for no more than 2 cycles per fetch. `ram_req` drops between fetches.
- R8: `scl_hold` is high from the cycle after a fetch starts until its odd byte is in the shadow. No `tx_load` occurs while the grant is withheld.
- R9: While `ram_req` is high and not granted, `ram_addr` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | One-cycle pulse: read command addressed to this slave |
| rd_addr | input | AW | Current buffer address when `rd_cmd` arrives |
| byte_req | input | 1 | One-cycle pulse: master wants another byte |
| msg_end | input | 1 | One-cycle pulse: stop or repeated start seen |
| ram_req | output | 1 | Buffer RAM read request |
| ram_addr | output | AW | Buffer RAM read address |
| ram_gnt | input | 1 | Grant; data appears on `ram_rdata` the next cycle |
| ram_rdata | input | 8 | Buffer RAM read data |
| cpu_stall | output | 1 | CPU held off while the block uses the RAM |
| scl_hold | output | 1 | Keep serial clock stretched, fetch in progress |
| tx_load | output | 1 | Load `tx_data` into the transmit shift register |
| tx_data | output | 8 | Byte to transmit |

## Verification
The hardest case to reach is a torn word. A CPU write must land on the odd address in the window after the burst has completed and before the master asks for the second byte. The bench writes the RAM model in exactly that window and expects the old value. It also withholds the grant for several cycles to hold the fetch open. During that time it checks that the clock stays held and the address stays steady, and that an abort in that window loads nothing. Further sequences cover an odd start address, an address wrap across the buffer top, and a one-byte read followed by a fresh command that must overwrite the stale shadow.

// File: rtl/wcr_pkg.sv
package wcr_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_EVEN = 2'd1,
        FS_ODD  = 2'd2
    } fetch_state_e;

    typedef struct packed {
        logic start;
        logic advance;
        logic abort;
        logic send_shadow;
    } wcr_ctl_t;

    typedef struct packed {
        logic  load;
        byte_t data;
    } tx_slot_t;

    function automatic logic is_fetching(fetch_state_e s);
        return s != FS_IDLE;
    endfunction
endpackage

// File: rtl/wcr_msg_tracker.sv
module wcr_msg_tracker
    import wcr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rd_cmd,
    input  logic     msg_end,
    input  logic     byte_req,
    input  logic     shadow_valid,
    input  logic     fetch_busy,
    output wcr_ctl_t ctl
);
    logic in_msg_q;
    logic quiet;

    always_ff @(posedge clk) begin
        if (rst)          in_msg_q <= 1'b0;
        else if (rd_cmd)  in_msg_q <= 1'b1;
        else if (msg_end) in_msg_q <= 1'b0;
    end

    assign quiet = !rd_cmd && !msg_end;

    always_comb begin
        ctl.start       = rd_cmd;
        ctl.abort       = msg_end && !rd_cmd;
        ctl.send_shadow = byte_req && in_msg_q && shadow_valid && quiet;
        ctl.advance     = byte_req && in_msg_q && !shadow_valid && !fetch_busy && quiet;
    end
endmodule

// File: rtl/wcr_fetch_engine.sv
module wcr_fetch_engine
    import wcr_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  wcr_ctl_t      ctl,
    input  logic [AW-1:0] start_addr,
    input  logic          ram_gnt,
    output logic          ram_req,
    output logic [AW-1:0] ram_addr,
    output logic          cpu_stall,
    output logic          even_vld,
    output logic          odd_vld,
    output logic          busy
);
    localparam logic [AW-1:0] STEP = AW'(2);
    localparam logic [AW-1:0] LSB  = AW'(1);

    fetch_state_e  state_q;
    logic [AW-1:0] base_q;
    logic          pend_even_q;
    logic          pend_odd_q;
    logic          kill;

    assign kill = ctl.start || ctl.abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= FS_IDLE;
            base_q      <= '0;
            pend_even_q <= 1'b0;
            pend_odd_q  <= 1'b0;
        end else begin
            pend_even_q <= (state_q == FS_EVEN) && ram_gnt && !kill;
            pend_odd_q  <= (state_q == FS_ODD) && ram_gnt && !kill;
            if (ctl.start) begin
                state_q <= FS_EVEN;
                base_q  <= start_addr & ~LSB;
            end else if (ctl.abort) begin
                state_q <= FS_IDLE;
            end else if (ctl.advance) begin
                state_q <= FS_EVEN;
                base_q  <= base_q + STEP;
            end else begin
                unique case (state_q)
                    FS_EVEN: if (ram_gnt) state_q <= FS_ODD;
                    FS_ODD:  if (ram_gnt) state_q <= FS_IDLE;
                    default: state_q <= FS_IDLE;
                endcase
            end
        end
    end

    assign ram_req   = is_fetching(state_q);
    assign ram_addr  = (state_q == FS_ODD) ? (base_q | LSB) : base_q;
    assign cpu_stall = ram_req && ram_gnt;
    assign even_vld  = pend_even_q;
    assign odd_vld   = pend_odd_q;
    assign busy      = ram_req || pend_even_q || pend_odd_q;
endmodule

// File: rtl/wcr_shadow_reg.sv
module wcr_shadow_reg
    import wcr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  capture,
    input  logic  consume,
    input  byte_t din,
    output byte_t dout,
    output logic  valid
);
    byte_t data_q;
    logic  valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (capture) data_q <= din;
            if (clr)          valid_q <= 1'b0;
            else if (capture) valid_q <= 1'b1;
            else if (consume) valid_q <= 1'b0;
        end
    end

    assign dout  = data_q;
    assign valid = valid_q;
endmodule

// File: rtl/wcr_prefetch.sv
module wcr_prefetch
    import wcr_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_cmd,
    input  logic [AW-1:0] rd_addr,
    input  logic          byte_req,
    input  logic          msg_end,
    output logic          ram_req,
    output logic [AW-1:0] ram_addr,
    input  logic          ram_gnt,
    input  logic [7:0]    ram_rdata,
    output logic          cpu_stall,
    output logic          scl_hold,
    output logic          tx_load,
    output logic [7:0]    tx_data
);
    wcr_ctl_t ctl;
    logic     shadow_valid;
    byte_t    shadow_data;
    logic     even_vld;
    logic     odd_vld;
    logic     busy;
    tx_slot_t tx_q;
    tx_slot_t tx_d;

    wcr_msg_tracker u_track (
        .clk          (clk),
        .rst          (rst),
        .rd_cmd       (rd_cmd),
        .msg_end      (msg_end),
        .byte_req     (byte_req),
        .shadow_valid (shadow_valid),
        .fetch_busy   (busy),
        .ctl          (ctl)
    );

    wcr_fetch_engine #(.AW(AW)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .start_addr (rd_addr),
        .ram_gnt    (ram_gnt),
        .ram_req    (ram_req),
        .ram_addr   (ram_addr),
        .cpu_stall  (cpu_stall),
        .even_vld   (even_vld),
        .odd_vld    (odd_vld),
        .busy       (busy)
    );

    wcr_shadow_reg u_shadow (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctl.start || msg_end),
        .capture (odd_vld && !ctl.start && !msg_end),
        .consume (ctl.send_shadow),
        .din     (ram_rdata),
        .dout    (shadow_data),
        .valid   (shadow_valid)
    );

    always_comb begin
        tx_d.load = (even_vld && !ctl.start && !ctl.abort) || ctl.send_shadow;
        tx_d.data = even_vld ? ram_rdata : shadow_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else begin
            tx_q.load <= tx_d.load;
            if (tx_d.load) tx_q.data <= tx_d.data;
        end
    end

    assign tx_load  = tx_q.load;
    assign tx_data  = tx_q.data;
    assign scl_hold = busy;
endmodule

// File: rtl/wcr_prefetch_chk.sv
module wcr_prefetch_chk #(
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_cmd,
    input logic          msg_end,
    input logic          ram_req,
    input logic          ram_gnt,
    input logic [AW-1:0] ram_addr,
    input logic          cpu_stall,
    input logic          scl_hold,
    input logic          tx_load
);
    logic [2:0] stall_run;

    always_ff @(posedge clk) begin
        if (rst || !ram_req || rd_cmd) stall_run <= '0;
        else if (cpu_stall && stall_run != 3'd7) stall_run <= stall_run + 3'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!ram_req && !tx_load && !cpu_stall && !scl_hold)); // R1

    AST_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (rst)
        (ram_req && ram_gnt && !ram_addr[0] && !rd_cmd && !msg_end)
        |=> (ram_req && ram_addr == ($past(ram_addr) | AW'(1)))); // R2

    AST_NO_TX_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        (msg_end && !rd_cmd) |=> !tx_load); // R5

    AST_STALL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |-> (stall_run < 3'd2)); // R7

    AST_STALL_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |-> ram_gnt); // R7

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ram_req && !ram_gnt && !rd_cmd && !msg_end) |=> (ram_req && $stable(ram_addr))); // R9

    AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
        ram_req |-> scl_hold); // R8
endmodule

bind wcr_prefetch wcr_prefetch_chk #(.AW(AW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rd_cmd    (rd_cmd),
    .msg_end   (msg_end),
    .ram_req   (ram_req),
    .ram_gnt   (ram_gnt),
    .ram_addr  (ram_addr),
    .cpu_stall (cpu_stall),
    .scl_hold  (scl_hold),
    .tx_load   (tx_load)
);

// File: tb/wcr_prefetch_tb_top.sv
`timescale 1ns/100ps
module wcr_prefetch_tb_top;
    localparam int unsigned AW = 8;
    localparam int unsigned DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_cmd = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          byte_req = 1'b0;
    logic          msg_end = 1'b0;
    logic          ram_req;
    logic [AW-1:0] ram_addr;
    logic          ram_gnt;
    logic [7:0]    ram_rdata = '0;
    logic          cpu_stall;
    logic          scl_hold;
    logic          tx_load;
    logic [7:0]    tx_data;
    logic          gnt_en = 1'b1;

    logic [7:0]    mem [DEPTH];
    int            checks = 0;
    int            failures = 0;
    logic [7:0]    exp_q [$];
    string         tag_q [$];
    int            stall_cnt = 0;
    logic          req_seen = 1'b0;
    logic          done = 1'b0;

    always #2 clk = ~clk;

    wcr_prefetch #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .rd_addr(rd_addr),
        .byte_req(byte_req), .msg_end(msg_end), .ram_req(ram_req),
        .ram_addr(ram_addr), .ram_gnt(ram_gnt), .ram_rdata(ram_rdata),
        .cpu_stall(cpu_stall), .scl_hold(scl_hold), .tx_load(tx_load),
        .tx_data(tx_data)
    );

    assign ram_gnt = ram_req && gnt_en;

    always @(posedge clk) if (ram_req && ram_gnt) ram_rdata <= mem[ram_addr];

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] b, input string req);
        exp_q.push_back(b);
        tag_q.push_back(req);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (ram_req) req_seen <= 1'b1;
            if (cpu_stall) stall_cnt++;
            if (!ram_req && stall_cnt != 0) begin
                chk(stall_cnt <= 2, "R7 stall cycles per fetch", stall_cnt, 2);
                stall_cnt = 0;
            end
            if (tx_load) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected tx_load", tx_data, 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    chk(tx_data == e, t, tx_data, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_cmd(input logic [AW-1:0] a);
        rd_addr = a; rd_cmd = 1'b1; tick(1); rd_cmd = 1'b0;
    endtask

    task automatic pulse_req();
        byte_req = 1'b1; tick(1); byte_req = 1'b0;
    endtask

    task automatic pulse_end();
        msg_end = 1'b1; tick(1); msg_end = 1'b0;
    endtask

    task automatic wait_idle();
        tick(1);
        while (scl_hold) tick(1);
        tick(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i * 37 + 11);
        tick(3);
        chk(!tx_load && !ram_req && !cpu_stall && !scl_hold, "R1 outputs in reset",
            {tx_load, ram_req, cpu_stall, scl_hold}, 0);
        rst = 1'b0;
        tick(1);
        chk(!tx_load && !ram_req && !cpu_stall && !scl_hold, "R1 outputs after reset",
            {tx_load, ram_req, cpu_stall, scl_hold}, 0);

        // R2 even byte first, R3 torn-word protection, R4 next word
        expect_byte(mem[10], "R2 even byte of word at 10");
        pulse_cmd(8'd10);
        wait_idle();
        expect_byte(mem[11], "R3 shadow keeps fetch-time odd byte");
        mem[11] = 8'hEE;
        pulse_req();
        wait_idle();
        expect_byte(mem[12], "R4 next word even byte");
        pulse_req();
        wait_idle();
        expect_byte(mem[13], "R4 next word odd byte");
        pulse_req();
        wait_idle();
        pulse_end();

        // R5 byte request after message end is ignored
        tick(1);
        req_seen = 1'b0;
        pulse_req();
        tick(6);
        chk(!req_seen, "R5 no RAM request after msg_end", req_seen, 0);
        chk(exp_q.size() == 0, "R5 no pending expectation", exp_q.size(), 0);

        // R2 odd start address aligns down; R6 new command overwrites shadow
        expect_byte(mem[30], "R2 odd address aligned to 30");
        pulse_cmd(8'd31);
        wait_idle();
        pulse_end();
        expect_byte(mem[40], "R6 even byte of new word");
        pulse_cmd(8'd40);
        wait_idle();
        expect_byte(mem[41], "R6 shadow holds new odd byte");
        pulse_req();
        wait_idle();
        pulse_end();

        // R8 / R9 late grant
        gnt_en = 1'b0;
        expect_byte(mem[50], "R8 even byte after late grant");
        pulse_cmd(8'd50);
        for (int k = 0; k < 5; k++) begin
            chk(scl_hold && !tx_load, "R8 clock held, no load while grant withheld",
                {scl_hold, tx_load}, 2'b10);
            chk(ram_req && ram_addr == 8'd50 && !cpu_stall, "R9 address stable while waiting",
                ram_addr, 50);
            tick(1);
        end
        gnt_en = 1'b1;
        wait_idle();
        chk(!scl_hold, "R8 clock released after fetch", scl_hold, 0);
        expect_byte(mem[51], "R8 odd byte after late grant");
        pulse_req();
        wait_idle();
        pulse_end();

        // R4 wrap across buffer top
        expect_byte(mem[254], "R4 even byte at 254");
        pulse_cmd(8'd254);
        wait_idle();
        expect_byte(mem[255], "R4 odd byte at 255");
        pulse_req();
        wait_idle();
        expect_byte(mem[0], "R4 wrapped even byte at 0");
        pulse_req();
        wait_idle();
        pulse_end();

        // R5 abort during fetch loads nothing
        gnt_en = 1'b0;
        pulse_cmd(8'd60);
        tick(2);
        pulse_end();
        gnt_en = 1'b1;
        tick(6);
        chk(!ram_req && !scl_hold, "R5 fetch aborted by msg_end", {ram_req, scl_hold}, 0);

        tick(4);
        chk(exp_q.size() == 0, "R2 all expected bytes transmitted", exp_q.size(), 0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule